// File: doc/BRIEF.md
# Nonvolatile Save/Restore Command Sequence Detector

This block sits beside a byte-wide memory bus and watches the accesses made to it. A host asks for a nonvolatile save of the memory contents, or for a restore from the nonvolatile copy, by reading six particular addresses back to back. The detector follows the host's progress through that sequence. It issues a one-cycle save or restore request when the last read arrives, and it forgets any partial progress as soon as the host does anything else.

Every qualified bus access arrives as a one-cycle strobe with an address and a write flag. Cycles without a strobe neither advance nor break the sequence. Only the low 14 address bits are decoded. The output-enable state that travels with a read does not affect the result. A busy input, raised by the transfer engine while a save or restore runs, makes the detector deaf to the bus and holds it at the start.

Top module: `nvseq_detector`

## Requirements
- R1: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 (low 14 address bits) raise `store_req` in the cycle after the sixth strobe. Cycles with `acc_valid` low between the steps do not disturb progress.
- R2: The same five-read prefix followed by a read of 0x0C63 raises `recall_req` in the cycle after the sixth strobe.
- R3: Address bit 14 takes no part in decoding. A sequence run with bit 14 set on every step gives the same request.
- R4: A strobe with `acc_write` high at any step, even to the expected address, abandons the sequence. No request results until a fresh six-read sequence starts.
- R5: A read of any address other than the next expected one abandons the sequence. This includes reading the same address twice in a row.
- R6: After the five-read prefix, a read of 0x339C gives neither request and returns the detector to its start, so a following 0x0FC0 read alone does nothing.
- R7: The level of `acc_oe` never changes whether a step counts.
- R8: The read that abandons a sequence is judged again as a first step. If it is 0x0E38, the next expected address is 0x31C7.
- R9: Each request lasts exactly one cycle. `store_req` and `recall_req` are never high together. After a request the detector is back at its start.
- R10: While `busy` is high, strobes are ignored and the detector is held at its start. A sixth read that arrives in a busy cycle gives no request.
- R11: A synchronous active-high `rst` clears both requests and returns the detector to its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Nonvolatile transfer in progress; strobes ignored |
| acc_valid | input | 1 | One-cycle strobe marking a bus access |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_oe | input | 1 | Output-enable level of the access (not decoded) |
| acc_addr | input | 15 | Access address |
| store_req | output | 1 | One-cycle nonvolatile save request |
| recall_req | output | 1 | One-cycle restore request |

## Verification
The sixth, command-choosing read and the busy hold can land in the same cycle. The bench provokes this by raising `busy` in the cycle that carries the final 0x0FC0 strobe, after a clean prefix. It is judged correct only if no request appears and a later 0x0FC0 read alone also does nothing, because busy must both suppress the request and clear the progress. The abort and a new first step also share a cycle. The bench provokes this by placing 0x0E38 where a later address was expected, and expects a save from the five reads that follow.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int KEY_W     = 14;
    localparam int NUM_STEPS = 6;
    localparam int LAST_STEP = NUM_STEPS - 1;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam key_t KEY_SAVE     = 14'h0FC0;
    localparam key_t KEY_RESTORE  = 14'h0C63;
    localparam key_t KEY_RESERVED = 14'h339C;

    typedef struct packed {
        logic valid;
        logic write;
        key_t key;
    } probe_t;

    typedef enum logic [2:0] {
        V_IDLE,
        V_ADVANCE,
        V_ABORT,
        V_FIRE_SAVE,
        V_FIRE_RESTORE,
        V_RESERVED
    } verdict_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SAVE,
        CMD_RESTORE
    } cmd_e;

    // Shared prefix key expected at a given progress count.
    function automatic key_t prefix_key(input step_t idx);
        key_t k;
        case (idx)
            step_t'(0): k = 14'h0E38;
            step_t'(1): k = 14'h31C7;
            step_t'(2): k = 14'h03E0;
            step_t'(3): k = 14'h3C1F;
            step_t'(4): k = 14'h303F;
            default:    k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nvseq_classify.sv
module nvseq_classify
    import nvseq_pkg::*;
(
    input  step_t    step,
    input  probe_t   probe,
    output verdict_e verdict,
    output logic     first_hit
);

    logic prefix_ok;

    assign prefix_ok = (probe.key == prefix_key(step));
    assign first_hit = probe.valid && !probe.write
                       && (probe.key == prefix_key(step_t'(0)));

    always_comb begin
        verdict = V_IDLE;
        if (probe.valid) begin
            if (probe.write) begin
                verdict = V_ABORT;
            end else if (step < step_t'(LAST_STEP)) begin
                verdict = prefix_ok ? V_ADVANCE : V_ABORT;
            end else if (probe.key == KEY_SAVE) begin
                verdict = V_FIRE_SAVE;
            end else if (probe.key == KEY_RESTORE) begin
                verdict = V_FIRE_RESTORE;
            end else if (probe.key == KEY_RESERVED) begin
                verdict = V_RESERVED;
            end else begin
                verdict = V_ABORT;
            end
        end
    end

endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
    import nvseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  verdict_e verdict,
    input  logic     first_hit,
    output step_t    step
);

    step_t step_q;
    step_t step_d;

    always_comb begin
        step_d = step_q;
        if (hold) begin
            step_d = '0;
        end else begin
            case (verdict)
                V_IDLE:    step_d = step_q;
                V_ADVANCE: step_d = step_t'(step_q + step_t'(1));
                V_ABORT:   step_d = first_hit ? step_t'(1) : '0;
                default:   step_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assign step = step_q;

endmodule

// File: rtl/nvseq_cmd_out.sv
module nvseq_cmd_out
    import nvseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  verdict_e verdict,
    output logic     store_req,
    output logic     recall_req
);

    cmd_e cmd_q;
    cmd_e cmd_d;

    always_comb begin
        cmd_d = CMD_NONE;
        if (!hold) begin
            case (verdict)
                V_FIRE_SAVE:    cmd_d = CMD_SAVE;
                V_FIRE_RESTORE: cmd_d = CMD_RESTORE;
                default:        cmd_d = CMD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= CMD_NONE;
        else     cmd_q <= cmd_d;
    end

    assign store_req  = (cmd_q == CMD_SAVE);
    assign recall_req = (cmd_q == CMD_RESTORE);

endmodule

// File: rtl/nvseq_detector.sv
module nvseq_detector
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_oe,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              store_req,
    output logic              recall_req
);

    localparam int HIGH_W = ADDR_W - KEY_W;

    probe_t   probe;
    verdict_e verdict;
    logic     first_hit;
    step_t    step;

    // Upper address bits and output enable are deliberately not decoded.
    logic [HIGH_W:0] unused_bits;
    assign unused_bits = {acc_oe, acc_addr[ADDR_W-1:KEY_W]};

    assign probe.valid = acc_valid && !busy;
    assign probe.write = acc_write;
    assign probe.key   = acc_addr[KEY_W-1:0];

    nvseq_classify u_classify (
        .step      (step),
        .probe     (probe),
        .verdict   (verdict),
        .first_hit (first_hit)
    );

    nvseq_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .hold      (busy),
        .verdict   (verdict),
        .first_hit (first_hit),
        .step      (step)
    );

    nvseq_cmd_out u_cmd (
        .clk        (clk),
        .rst        (rst),
        .hold       (busy),
        .verdict    (verdict),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

endmodule

// File: rtl/nvseq_detector_chk.sv
module nvseq_detector_chk
    import nvseq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic busy,
    input logic acc_valid,
    input logic acc_write,
    input key_t acc_key,
    input logic store_req,
    input logic recall_req
);

    assert_cmd_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_req, recall_req}));

    assert_store_single_R9: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);

    assert_recall_single_R9: assert property (@(posedge clk) disable iff (rst)
        recall_req |=> !recall_req);

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !(store_req || recall_req));

    assert_store_from_read_R4: assert property (@(posedge clk) disable iff (rst)
        store_req |-> $past(acc_valid && !acc_write));

    assert_recall_from_read_R4: assert property (@(posedge clk) disable iff (rst)
        recall_req |-> $past(acc_valid && !acc_write));

    assert_store_key_R1: assert property (@(posedge clk) disable iff (rst)
        store_req |-> ($past(acc_key) == KEY_SAVE));

    assert_recall_key_R2: assert property (@(posedge clk) disable iff (rst)
        recall_req |-> ($past(acc_key) == KEY_RESTORE));

endmodule

bind nvseq_detector nvseq_detector_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_key    (acc_addr[13:0]),
    .store_req  (store_req),
    .recall_req (recall_req)
);

// File: tb/nvseq_detector_test.sv
`timescale 1ns/1ps
module nvseq_detector_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_oe = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        store_req;
    logic        recall_req;

    int checks = 0;
    int errors = 0;
    logic seen_s;
    logic seen_r;

    always #4 clk = ~clk;

    nvseq_detector uut (
        .clk(clk), .rst(rst), .busy(busy), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_oe(acc_oe), .acc_addr(acc_addr),
        .store_req(store_req), .recall_req(recall_req)
    );

    localparam logic [14:0] PFX [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives one strobe and samples outputs one edge later.
    task automatic access(input bit wr, input bit oe, input logic [14:0] a);
        acc_valid = 1'b1; acc_write = wr; acc_oe = oe; acc_addr = a;
        @(negedge clk);
        seen_s = store_req; seen_r = recall_req;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic prefix(input logic [14:0] hi);
        for (int i = 0; i < 5; i++) access(1'b0, 1'b0, PFX[i] | hi);
    endtask

    task automatic expect_out(input bit s, input bit r, input string tag);
        check(seen_s == s && seen_r == r, tag, {seen_s, seen_r}, {s, r});
    endtask

    task automatic t_reset;
        check(store_req == 0 && recall_req == 0, "R11 reset outputs", {store_req, recall_req}, 0);
        prefix(15'h0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R11 reset drops progress");
    endtask

    task automatic t_store;
        prefix(15'h0);
        expect_out(0, 0, "R1 no request during prefix");
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(1, 0, "R1 store request");
        @(negedge clk);
        check(store_req == 0, "R9 single-cycle store", store_req, 0);
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R9 back to start after request");
    endtask

    task automatic t_gaps;
        for (int i = 0; i < 5; i++) begin
            access(1'b0, 1'b0, PFX[i]);
            idle(i + 1);
        end
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(1, 0, "R1 store with idle gaps");
    endtask

    task automatic t_recall;
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h0C63);
        expect_out(0, 1, "R2 recall request");
        @(negedge clk);
        check(recall_req == 0, "R9 single-cycle recall", recall_req, 0);
    endtask

    task automatic t_bit14;
        prefix(15'h4000);
        access(1'b0, 1'b0, 15'h4C63);
        expect_out(0, 1, "R3 bit 14 ignored");
    endtask

    task automatic t_write;
        access(1'b0, 1'b0, PFX[0]); access(1'b0, 1'b0, PFX[1]); access(1'b0, 1'b0, PFX[2]);
        access(1'b1, 1'b0, PFX[3]);
        access(1'b0, 1'b0, PFX[4]);
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R4 write mid-sequence aborts");
        prefix(15'h0);
        access(1'b1, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R4 write as final step");
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R4 final after write");
    endtask

    task automatic t_mismatch;
        access(1'b0, 1'b0, PFX[0]); access(1'b0, 1'b0, PFX[1]); access(1'b0, 1'b0, PFX[1]);
        access(1'b0, 1'b0, PFX[2]); access(1'b0, 1'b0, PFX[3]); access(1'b0, 1'b0, PFX[4]);
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R5 repeated read aborts");
        access(1'b0, 1'b0, PFX[0]); access(1'b0, 1'b0, PFX[1]); access(1'b0, 1'b0, 15'h1234);
        access(1'b0, 1'b0, PFX[3]); access(1'b0, 1'b0, PFX[4]);
        access(1'b0, 1'b0, 15'h0C63);
        expect_out(0, 0, "R5 wrong address aborts");
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h0FC1);
        expect_out(0, 0, "R5 wrong final address");
    endtask

    task automatic t_reserved;
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h339C);
        expect_out(0, 0, "R6 reserved final step");
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R6 reserved resets progress");
    endtask

    task automatic t_oe;
        for (int i = 0; i < 5; i++) access(1'b0, i[0], PFX[i]);
        access(1'b0, 1'b1, 15'h0FC0);
        expect_out(1, 0, "R7 output enable ignored");
    endtask

    task automatic t_restart;
        access(1'b0, 1'b0, PFX[0]); access(1'b0, 1'b0, PFX[1]);
        access(1'b0, 1'b0, PFX[0]);
        access(1'b0, 1'b0, PFX[1]); access(1'b0, 1'b0, PFX[2]);
        access(1'b0, 1'b0, PFX[3]); access(1'b0, 1'b0, PFX[4]);
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(1, 0, "R8 abort read restarts sequence");
        access(1'b0, 1'b0, PFX[0]);
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h0C63);
        expect_out(0, 1, "R8 doubled first read restarts");
    endtask

    task automatic t_busy;
        prefix(15'h0);
        busy = 1'b1; @(negedge clk); busy = 1'b0;
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R10 busy clears progress");
        prefix(15'h0);
        busy = 1'b1;
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R10 final read in busy cycle");
        busy = 1'b0;
        access(1'b0, 1'b0, 15'h0FC0);
        expect_out(0, 0, "R10 no progress kept after busy");
        busy = 1'b1;
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h0C63);
        expect_out(0, 0, "R10 whole sequence while busy");
        busy = 1'b0;
        prefix(15'h0);
        access(1'b0, 1'b0, 15'h0C63);
        expect_out(0, 1, "R10 works after busy drops");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_store();
                t_gaps();
                t_recall();
                t_bit14();
                t_write();
                t_mismatch();
                t_reserved();
                t_oe();
                t_restart();
                t_busy();
                idle(2);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule